// File: doc/BRIEF.md
# Two-Level Cascaded Lookup Evaluator

This block turns a wide input pattern into a short decision word through three writable lookup memories arranged in two levels. The input word is cut into two equal halves. Each half addresses its own first-level memory, and each of those memories returns a short intermediate code. The two codes are placed side by side to form the address of one final memory, whose entry is the decision. Split this way, a 32-input function fits in three 64K-entry memories instead of one memory with 4G entries.

A host fills the memories at run time through a single write port. That port carries a table selector, an address, a data word and a strobe. Evaluation is fully pipelined and accepts one new pattern on every clock. Each memory read has its own register stage so that the block can reach high clock rates. A valid flag travels through the pipeline beside the data. At full size the parameters are HALF_W = 16, MID_W = 8 and OUT_W = 8: 32 inputs, three 65536 x 8 memories and an 8-bit result. The defaults are smaller, so that an elaboration with default values builds only small memories.

Top module: `cascade_lut`

## Requirements
- R1: The low first-level memory is addressed by `in_data[HALF_W-1:0]`. The high first-level memory is addressed by `in_data[2*HALF_W-1:HALF_W]`. Each returns a MID_W-bit code.
- R2: The final memory is addressed by `{high code, low code}`, with the high-half code in the upper MID_W bits. Its OUT_W-bit entry is the result.
- R3: A pattern sampled with `in_valid` high at clock edge e appears on `out_data`, with `out_valid` high, after edge e+2. That is, the result is seen in the third cycle after the input cycle. Every sampled pattern yields exactly one result, in order.
- R4: A host write with `host_wr` high at an edge stores data in the memory chosen by `host_sel`: 0 = low first-level, 1 = high first-level, 2 = final. The address is the low bits of `host_addr` (HALF_W bits for the first level, 2*MID_W bits for the final memory). The data is the low bits of `host_data` (MID_W bits for the first level, OUT_W bits for the final memory). At most one memory is written per edge.
- R5: A host write with `host_sel` = 3 changes no memory.
- R6: When a lookup reads an entry on the same edge that the host writes that entry, the lookup returns the previous contents. Later lookups return the new contents.
- R7: A synchronous active-low reset (`rst_n` low at an edge) drops every pattern in flight. After reset, `out_valid` is 0 and `out_data` is 0. No result from a pattern accepted before the reset ever appears. Memory contents are kept.
- R8: Patterns presented on consecutive cycles, or with idle cycles between them, are each evaluated against the memory contents at the time they are read.
- R9: While `out_valid` is low, `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset for the pipeline flags and the result register |
| in_valid | input | 1 | Pattern on `in_data` is to be evaluated |
| in_data | input | 2*HALF_W | Input pattern |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Memory selector: 0 low, 1 high, 2 final, 3 none |
| host_addr | input | max(HALF_W, 2*MID_W) | Host write address |
| host_data | input | max(MID_W, OUT_W) | Host write data |
| out_valid | output | 1 | `out_data` holds a new result |
| out_data | output | OUT_W | Decision word |

## Verification
The bench builds the block with HALF_W = 6, MID_W = 3 and OUT_W = 8. Each memory then has 64 entries, so the bench can write every entry of all three memories and keep a full mirror of them. With 3-bit codes, explicit writes can steer chosen patterns onto known final entries. This is how it shows that a selector value of 3 writes nothing, that a same-edge write returns the old entry, and that contents survive reset. Under the same small setting, the all-zero and all-one halves and single-bit walks reach the edge addresses of every memory.

// File: rtl/cascade_lut_pkg.sv
// Package: shared definitions for the cascaded lookup evaluator.
// Assumes: the host selector is two bits wide and codes 0..2 name memories.
package cascade_lut_pkg;

    // Host selector codes; each names one memory, or none.
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_FIN  = 2'd2,
        SEL_NONE = 2'd3
    } lut_sel_e;

    // Number of memories that the host port can reach.
    localparam int LUT_COUNT = 3;

    // Number of register stages between the input and the result.
    localparam int PIPE_STAGES = 3;

endpackage

// File: rtl/cascade_lut_ram.sv
// Module: one lookup memory with a registered read port and a write port.
// Assumes: the read always takes the contents from before a same-edge
// write (read-before-write). The contents are never reset.
module cascade_lut_ram #(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Purpose: store the host data.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: registered read; it sees the contents from before the write.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cascade_lut_wr_decode.sv
// Module: turns the host strobe and selector into one write enable per
// memory. Assumes: selector codes follow lut_sel_e; the spare code
// enables nothing.
module cascade_lut_wr_decode
    import cascade_lut_pkg::*;
(
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    output logic [LUT_COUNT-1:0] tbl_we
);

    // Purpose: one comparator per memory.
    for (genvar g = 0; g < LUT_COUNT; g++) begin : g_dec
        assign tbl_we[g] = wr_en && (wr_sel == 2'(g));
    end

endmodule

// File: rtl/cascade_lut_valid_pipe.sv
// Module: shift register that carries the valid flag beside the data.
// Assumes: rst_n is synchronous and active low, and clears every stage.
module cascade_lut_valid_pipe #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    output logic [STAGES-1:0] stage_v
);

    // Purpose: move the flag one stage per clock, or flush it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_v <= '0;
        end else begin
            stage_v <= {stage_v[STAGES-2:0], in_v};
        end
    end

endmodule

// File: rtl/cascade_lut.sv
// Module: two-level cascaded lookup. Two first-level memories each read
// one half of the input. Their codes, joined as {high, low}, address the
// final memory. A result register follows.
// Assumes: latency 3; one pattern per clock; host writes may hit
// any memory at any time (read-before-write).
module cascade_lut
    import cascade_lut_pkg::*;
#(
    parameter int HALF_W = 10,
    parameter int MID_W  = 5,
    parameter int OUT_W  = 8,
    localparam int IN_W    = 2 * HALF_W,
    localparam int FIN_AW  = 2 * MID_W,
    localparam int HOST_AW = (HALF_W > FIN_AW) ? HALF_W : FIN_AW,
    localparam int HOST_DW = (MID_W > OUT_W) ? MID_W : OUT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_data,
    input  logic               host_wr,
    input  logic [1:0]         host_sel,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_data,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data
);

    logic [LUT_COUNT-1:0]   tbl_we;
    logic [PIPE_STAGES-1:0] stage_v;
    logic [MID_W-1:0]       l1_q [2];
    logic [OUT_W-1:0]       fin_q;
    logic [OUT_W-1:0]       out_data_q;

    cascade_lut_wr_decode u_dec (
        .wr_en  (host_wr),
        .wr_sel (host_sel),
        .tbl_we (tbl_we)
    );

    cascade_lut_valid_pipe #(.STAGES(PIPE_STAGES)) u_vpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (in_valid),
        .stage_v (stage_v)
    );

    // First level: index 0 reads the low half, index 1 the high half.
    for (genvar g = 0; g < 2; g++) begin : g_l1
        cascade_lut_ram #(.AW(HALF_W), .DW(MID_W)) u_ram (
            .clk   (clk),
            .we    (tbl_we[g]),
            .waddr (host_addr[HALF_W-1:0]),
            .wdata (host_data[MID_W-1:0]),
            .raddr (in_data[g*HALF_W +: HALF_W]),
            .rdata (l1_q[g])
        );
    end

    // Second level: the address is the two codes, high code on top.
    cascade_lut_ram #(.AW(FIN_AW), .DW(OUT_W)) u_fin (
        .clk   (clk),
        .we    (tbl_we[SEL_FIN]),
        .waddr (host_addr[FIN_AW-1:0]),
        .wdata (host_data[OUT_W-1:0]),
        .raddr ({l1_q[1], l1_q[0]}),
        .rdata (fin_q)
    );

    // Purpose: load the result register only for a valid pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data_q <= '0;
        end else if (stage_v[1]) begin
            out_data_q <= fin_q;
        end
    end

    assign out_valid = stage_v[PIPE_STAGES-1];
    assign out_data  = out_data_q;

endmodule

// File: rtl/cascade_lut_chk.sv
// Module: assertion checker for cascade_lut, bound to every instance.
// Assumes: it watches only ports and the write-enable vector.
module cascade_lut_chk #(
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             host_wr,
    input logic [1:0]       host_sel,
    input logic [2:0]       tbl_we,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    logic [1:0] run_cnt;

    // Purpose: count the edges out of reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    assert_single_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_we));

    assert_no_strobe_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |-> (tbl_we == 3'b000));

    assert_spare_sel_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |-> (tbl_we == 3'b000));

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_reset_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_cnt == 2'd3));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt >= 2'd2) && !out_valid) |-> $stable(out_data));

endmodule

bind cascade_lut cascade_lut_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .tbl_we    (tbl_we),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_cascade_lut.sv
module sim_cascade_lut;

    localparam int HW  = 6;
    localparam int MW  = 3;
    localparam int OW  = 8;
    localparam int IW  = 2 * HW;
    localparam int N   = 1 << HW;
    localparam int QD  = 256;
    localparam int NV  = 16;

    // Stimulus: bit 12 = insert an idle cycle first, bits 11:0 = pattern.
    localparam logic [12:0] VEC [NV] = '{
        13'h0000, 13'h0FFF, 13'h003F, 13'h0FC0,
        13'h1041, 13'h0001, 13'h0040, 13'h0800,
        13'h1020, 13'h0A5C, 13'h05A3, 13'h1777,
        13'h0123, 13'h0CDE, 13'h1F0F, 13'h00F0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          host_wr = 1'b0;
    logic [1:0]    host_sel = '0;
    logic [HW-1:0] host_addr = '0;
    logic [OW-1:0] host_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    logic [OW-1:0] ref_lo  [N];
    logic [OW-1:0] ref_hi  [N];
    logic [OW-1:0] ref_fin [N];
    logic [OW-1:0] exp_q   [QD];
    int            exp_cyc [QD];
    int            wr_ptr = 0;
    int            rd_ptr = 0;
    int            cyc = 0;
    int            checks = 0;
    int            failures = 0;
    bit            mon_en = 1'b0;
    bit            have_last = 1'b0;
    bit            done = 1'b0;
    logic [OW-1:0] last_out = '0;
    logic [15:0]   lfsr = 16'hACE1;

    cascade_lut #(.HALF_W(HW), .MID_W(MW), .OUT_W(OW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .host_wr   (host_wr),
        .host_sel  (host_sel),
        .host_addr (host_addr),
        .host_data (host_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [OW-1:0] model(input logic [IW-1:0] w);
        logic [MW-1:0] lo_c;
        logic [MW-1:0] hi_c;
        lo_c = ref_lo[w[HW-1:0]][MW-1:0];
        hi_c = ref_hi[w[IW-1:HW]][MW-1:0];
        return ref_fin[{hi_c, lo_c}];
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Result monitor: R1, R2, R3, R9.
    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (rd_ptr == wr_ptr) begin
                    check(1'b0, "R7", "result with nothing in flight", 1, 0);
                end else begin
                    check(out_data == exp_q[rd_ptr % QD], "R2", "result word",
                          out_data, exp_q[rd_ptr % QD]);
                    check(cyc - exp_cyc[rd_ptr % QD] == 3, "R3", "latency",
                          cyc - exp_cyc[rd_ptr % QD], 3);
                    rd_ptr++;
                end
                last_out  = out_data;
                have_last = 1'b1;
            end else if (have_last) begin
                check(out_data == last_out, "R9", "hold while idle", out_data, last_out);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        host_wr  = 1'b0;
    endtask

    task automatic push(input logic [IW-1:0] w);
        exp_q[wr_ptr % QD]   = model(w);
        exp_cyc[wr_ptr % QD] = cyc;
        wr_ptr++;
        in_valid = 1'b1;
        in_data  = w;
    endtask

    task automatic apply_wr(input logic [1:0] sel, input logic [HW-1:0] a,
                            input logic [OW-1:0] d);
        host_wr   = 1'b1;
        host_sel  = sel;
        host_addr = a;
        host_data = d;
        case (sel)
            2'd0: ref_lo[a]  = d & OW'((1 << MW) - 1);
            2'd1: ref_hi[a]  = d & OW'((1 << MW) - 1);
            2'd2: ref_fin[a] = d;
            default: ;
        endcase
    endtask

    task automatic send(input logic [IW-1:0] w);
        @(negedge clk);
        host_wr = 1'b0;
        push(w);
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [HW-1:0] a,
                          input logic [OW-1:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        apply_wr(sel, a, d);
    endtask

    // Same edge: a lookup and a host write (expectation uses old contents).
    task automatic send_and_write(input logic [IW-1:0] w, input logic [1:0] sel,
                                  input logic [HW-1:0] a, input logic [OW-1:0] d);
        @(negedge clk);
        push(w);
        apply_wr(sel, a, d);
    endtask

    initial begin
        // Reset state (R7).
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid in reset", out_valid, 0);
        check(out_data == '0, "R7", "result in reset", out_data, 0);
        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;

        // Fill all three memories with pseudo-random contents (R4).
        for (int t = 0; t < 3; t++) begin
            for (int a = 0; a < N; a++) begin
                lfsr = lfsr_next(lfsr);
                hwrite(2'(t), HW'(a), lfsr[7:0]);
            end
        end

        // Known entries, then a write with the spare selector (R5).
        hwrite(2'd0, 6'd5, 8'd0);
        hwrite(2'd0, 6'd7, 8'd5);
        hwrite(2'd1, 6'd5, 8'd0);
        hwrite(2'd2, 6'd5, 8'h3C);
        hwrite(2'd2, 6'd61, 8'hC3);
        hwrite(2'd2, 6'd0, 8'h11);
        hwrite(2'd2, 6'd7, 8'h77);
        hwrite(2'd2, 6'd56, 8'h88);
        hwrite(2'd3, 6'd5, 8'hFF);
        send({6'd5, 6'd7});   // R5: high[5] and final[5] must be unchanged
        send({6'd5, 6'd5});   // R5: low[5] must be unchanged
        idle();

        // Vector walk with gaps: R1, R2, R3, R8, R9.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) idle();
            send(VEC[i][IW-1:0]);
        end
        idle();
        idle();

        // Read-before-write on the low first-level memory (R6).
        hwrite(2'd0, 6'd9, 8'd1);
        hwrite(2'd1, 6'd9, 8'd2);
        hwrite(2'd2, 6'd17, 8'h5A);
        hwrite(2'd2, 6'd22, 8'hA6);
        send_and_write({6'd9, 6'd9}, 2'd0, 6'd9, 8'd6);  // R6: expects 0x5A
        send({6'd9, 6'd9});                              // R6: expects 0xA6
        idle();
        repeat (4) idle();
        check(rd_ptr == wr_ptr, "R6", "results drained", rd_ptr, wr_ptr);

        // Reset with patterns in flight: flush, contents kept (R7).
        send(12'h145);
        send(12'h2B9);
        @(posedge clk);
        mon_en = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid after reset", out_valid, 0);
        check(out_data == '0, "R7", "result after reset", out_data, 0);
        rst_n = 1'b1;
        @(posedge clk);
        rd_ptr    = wr_ptr;
        have_last = 1'b0;
        mon_en    = 1'b1;
        repeat (5) idle();
        send({6'd5, 6'd5});   // R7: contents survive reset
        send({6'd9, 6'd9});
        repeat (6) idle();
        check(rd_ptr == wr_ptr, "R3", "every pattern produced a result", rd_ptr, wr_ptr);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R3 watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule